// File: doc/BRIEF.md
# DDS Single-Tone Configuration Sequencer

This block brings a serially programmed direct digital synthesizer from power-up to a single-tone output without any processor involvement. It first holds the synthesizer in reset. It then sends a fixed, ordered series of five 40-bit register writes through a 4-wire SPI master:

1. Calibration start.
2. Calibration stop, after a settling wait.
3. Profile-mode enable.
4. Profile 0 frequency tuning word.
5. Profile 0 amplitude scale.

After the last write it gives a single I/O update strobe, so that the buffered values take effect.

The tuning word and the amplitude come in on input ports and are read when their frames are loaded. The block also drives every side-band control pin of the synthesizer to a defined level, so that none is left floating. A floating profile select would make the device run from profile 7 instead of the programmed profile 0. A done flag reports completion. A start pulse while done, or a reset at any time, runs the whole sequence again.

Top module: `dds_cfg_sequencer`

## Requirements
- R1: `ddsReset` is high while `rstN` is low and stays high after `rstN` rises. When `start` is accepted, `ddsReset` is high for exactly RESET_CYCLES clock cycles. `csN` never goes low while `ddsReset` is high.
- R2: Every transfer is exactly 40 bits, sent MSB first, with `csN` low for the whole frame. `sdio` changes only while `sclk` is low, and the receiver samples it on the rising edge of `sclk`. `sclk` is low whenever `csN` is high. Frame bit 39 is the write flag (0). Bits 38:32 hold the register address, and bits 31:0 hold the data.
- R3: The first frame writes address 0x03 with data 0x01000000, which is the calibration bit 24 set.
- R4: The second frame writes address 0x03 with data 0x00000000. At least CAL_WAIT clock cycles pass between the end of the first frame and the start of the second.
- R5: The third frame writes address 0x01 with data 0x00800000, which is the profile-mode enable bit 23 set.
- R6: The fourth frame writes address 0x0B with `ftwIn` as the data.
- R7: The fifth frame writes address 0x0C with `ampIn` in bits 11:0 and zeros in bits 31:12.
- R8: After the fifth frame has ended, `ioUpdate` pulses high for exactly one cycle, while `csN` is high. This happens exactly once per sequence.
- R9: `profSel` is 3'b000, and `extPwrDown` and `syncIo` are 0, at all times.
- R10: `done` goes high the cycle after the update pulse and stays high until a new `start`. A `start` while the sequence is running has no effect.
- R11: Each run sends exactly five frames. A reset in the middle of a sequence aborts it and restarts the full sequence from R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Reruns the sequence when `done` is high |
| ftwIn | input | 32 | Profile 0 frequency tuning word |
| ampIn | input | 12 | Profile 0 amplitude scale |
| sclk | output | 1 | SPI serial clock |
| csN | output | 1 | SPI chip select, active low |
| sdio | output | 1 | SPI serial data to the synthesizer |
| ddsReset | output | 1 | Synthesizer master reset |
| ioUpdate | output | 1 | I/O update strobe |
| profSel | output | 3 | Profile select pins |
| extPwrDown | output | 1 | External power-down control, held inactive |
| syncIo | output | 1 | Sync I/O pin, held inactive |
| done | output | 1 | Sequence complete |

## Verification
The embedded assertions check on every cycle the serial line discipline:
- `sclk` is idle while chip select is high.
- Data is stable while `sclk` is high.
- Chip select stays high during reset.
- The update strobe lasts one cycle, comes only with the bus idle, and is followed by `done`.

Only the bench scenarios can show the order and content of the five frames, the calibration wait, the exact reset length, and the one-update-per-run count. The bench covers a sweep of walking-one tuning words with varied amplitudes, a start issued mid-run, and a reset issued mid-run.

// File: rtl/dds_seq_pkg.sv
package dds_seq_pkg;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 7;
  localparam int FRAME_W   = 1 + ADDR_W + DATA_W;
  localparam int NUM_WRITES = 5;

  localparam logic [ADDR_W-1:0] ADDR_CAL  = 7'h03;
  localparam logic [ADDR_W-1:0] ADDR_MODE = 7'h01;
  localparam logic [ADDR_W-1:0] ADDR_FTW0 = 7'h0B;
  localparam logic [ADDR_W-1:0] ADDR_AMP0 = 7'h0C;

  localparam int CAL_BIT     = 24;
  localparam int PROF_EN_BIT = 23;

  typedef struct packed {
    logic       load;
    logic [2:0] idx;
  } seqStrobe_t;
endpackage

// File: rtl/dds_seq_ctrl.sv
module dds_seq_ctrl
  import dds_seq_pkg::*;
#(
  parameter int RESET_CYCLES = 16,
  parameter int CAL_WAIT     = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       xferDone,
  output seqStrobe_t strobe,
  output logic       ddsReset,
  output logic       ioUpdate,
  output logic       done
);
  localparam int CNT_MAX = (RESET_CYCLES > CAL_WAIT) ? RESET_CYCLES : CAL_WAIT;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [2:0] LAST_IDX = 3'(NUM_WRITES - 1);

  typedef enum logic [2:0] {
    ST_RST, ST_LOAD, ST_XFER, ST_CALW, ST_UPD, ST_DONE
  } seqState_t;

  seqState_t        state;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       idx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_RST;
      cnt   <= '0;
      idx   <= '0;
    end else begin
      case (state)
        ST_RST: begin
          if (cnt == CNT_W'(RESET_CYCLES - 1)) begin
            state <= ST_LOAD;
            idx   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_LOAD: state <= ST_XFER;
        ST_XFER: begin
          if (xferDone) begin
            if (idx == 3'd0) begin
              state <= ST_CALW;
              cnt   <= '0;
            end else if (idx == LAST_IDX) begin
              state <= ST_UPD;
            end else begin
              idx   <= idx + 1'b1;
              state <= ST_LOAD;
            end
          end
        end
        ST_CALW: begin
          if (cnt == CNT_W'(CAL_WAIT - 1)) begin
            idx   <= 3'd1;
            state <= ST_LOAD;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_UPD: state <= ST_DONE;
        ST_DONE: begin
          if (start) begin
            state <= ST_RST;
            cnt   <= '0;
          end
        end
        default: state <= ST_RST;
      endcase
    end
  end

  assign strobe.load = (state == ST_LOAD);
  assign strobe.idx  = idx;
  assign ddsReset    = (state == ST_RST);
  assign ioUpdate    = (state == ST_UPD);
  assign done        = (state == ST_DONE);

  // R8: the update strobe lasts exactly one cycle
  assert_update_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    ioUpdate |=> !ioUpdate);

  // R10: done follows the update strobe
  assert_done_after_update_R10: assert property (@(posedge clk) disable iff (!rstN)
    ioUpdate |=> done);
endmodule

// File: rtl/dds_seq_spi.sv
module dds_seq_spi
  import dds_seq_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int AMP_W    = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic [DATA_W-1:0] ftwIn,
  input  logic [AMP_W-1:0]  ampIn,
  output logic             sclk,
  output logic             csN,
  output logic             sdio,
  output logic             xferDone
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int BIT_W = $clog2(FRAME_W);

  logic [FRAME_W-1:0] shiftReg;
  logic [FRAME_W-1:0] frame;
  logic [DIV_W-1:0]   divCnt;
  logic [BIT_W-1:0]   bitCnt;
  logic               tick;

  always_comb begin
    case (strobe.idx)
      3'd0:    frame = {1'b0, ADDR_CAL,  DATA_W'(1) << CAL_BIT};
      3'd1:    frame = {1'b0, ADDR_CAL,  {DATA_W{1'b0}}};
      3'd2:    frame = {1'b0, ADDR_MODE, DATA_W'(1) << PROF_EN_BIT};
      3'd3:    frame = {1'b0, ADDR_FTW0, ftwIn};
      default: frame = {1'b0, ADDR_AMP0, {{(DATA_W-AMP_W){1'b0}}, ampIn}};
    endcase
  end

  assign tick = (divCnt == DIV_W'(HALF_DIV - 1));
  assign sdio = shiftReg[FRAME_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      csN      <= 1'b1;
      sclk     <= 1'b0;
      divCnt   <= '0;
      bitCnt   <= '0;
      xferDone <= 1'b0;
    end else begin
      xferDone <= 1'b0;
      if (strobe.load) begin
        shiftReg <= frame;
        csN      <= 1'b0;
        sclk     <= 1'b0;
        divCnt   <= '0;
        bitCnt   <= '0;
      end else if (!csN) begin
        if (tick) begin
          divCnt <= '0;
          if (!sclk) begin
            sclk <= 1'b1;
          end else begin
            sclk <= 1'b0;
            if (bitCnt == BIT_W'(FRAME_W - 1)) begin
              csN      <= 1'b1;
              xferDone <= 1'b1;
            end else begin
              bitCnt   <= bitCnt + 1'b1;
              shiftReg <= {shiftReg[FRAME_W-2:0], 1'b0};
            end
          end
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
    end
  end

  // R2: serial clock idles low outside a frame
  assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);

  // R2: data holds while the serial clock is high
  assert_data_stable_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && sclk && $past(sclk) && $past(!csN)) |-> $stable(sdio));
endmodule

// File: rtl/dds_cfg_sequencer.sv
module dds_cfg_sequencer
  import dds_seq_pkg::*;
#(
  parameter int RESET_CYCLES = 16,
  parameter int CAL_WAIT     = 64,
  parameter int HALF_DIV     = 2,
  parameter int AMP_W        = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [31:0] ftwIn,
  input  logic [11:0] ampIn,
  output logic        sclk,
  output logic        csN,
  output logic        sdio,
  output logic        ddsReset,
  output logic        ioUpdate,
  output logic [2:0]  profSel,
  output logic        extPwrDown,
  output logic        syncIo,
  output logic        done
);
  seqStrobe_t strobe;
  logic       xferDone;

  dds_seq_ctrl #(
    .RESET_CYCLES(RESET_CYCLES),
    .CAL_WAIT    (CAL_WAIT)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .xferDone(xferDone),
    .strobe  (strobe),
    .ddsReset(ddsReset),
    .ioUpdate(ioUpdate),
    .done    (done)
  );

  dds_seq_spi #(
    .HALF_DIV(HALF_DIV),
    .AMP_W   (AMP_W)
  ) spi_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .ftwIn   (ftwIn),
    .ampIn   (ampIn[AMP_W-1:0]),
    .sclk    (sclk),
    .csN     (csN),
    .sdio    (sdio),
    .xferDone(xferDone)
  );

  // Profile 0 is the one programmed; side-band pins held inactive
  assign profSel    = 3'b000;
  assign extPwrDown = 1'b0;
  assign syncIo     = 1'b0;

  // R1: no serial transfer while the synthesizer is in reset
  assert_no_cs_in_reset_R1: assert property (@(posedge clk) disable iff (!rstN)
    ddsReset |-> csN);

  // R8: update strobe only with the bus idle
  assert_update_bus_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    ioUpdate |-> csN);
endmodule

// File: tb/dds_cfg_sequencer_tb.sv
module dds_cfg_sequencer_tb_top;
  localparam int RST_N  = 8;
  localparam int CAL_N  = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [31:0] ftwIn = '0;
  logic [11:0] ampIn = '0;
  logic sclk, csN, sdio, ddsReset, ioUpdate, extPwrDown, syncIo, done;
  logic [2:0] profSel;

  always #4 clk = ~clk;

  dds_cfg_sequencer #(.RESET_CYCLES(RST_N), .CAL_WAIT(CAL_N), .HALF_DIV(2), .AMP_W(12)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .ftwIn(ftwIn), .ampIn(ampIn),
    .sclk(sclk), .csN(csN), .sdio(sdio), .ddsReset(ddsReset), .ioUpdate(ioUpdate),
    .profSel(profSel), .extPwrDown(extPwrDown), .syncIo(syncIo), .done(done));

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor state
  int cyc = 0;
  logic [39:0] shiftIn;
  logic [39:0] frames [0:7];
  int csFall [0:7];
  int csRise [0:7];
  int nFrames, bits, updCount, updCyc, resetHigh;
  int lenBad, pinBad, csInReset, csInUpd, idleBad, dataBad;
  logic prevSclk = 1'b0, prevCs = 1'b1, prevSdio = 1'b0;

  task automatic clearMon();
    nFrames = 0; bits = 0; updCount = 0; updCyc = 0; resetHigh = 0;
    lenBad = 0; pinBad = 0; csInReset = 0; csInUpd = 0; idleBad = 0; dataBad = 0;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (profSel != 3'b000 || extPwrDown !== 1'b0 || syncIo !== 1'b0) pinBad++;
    if (ddsReset) resetHigh++;
    if (ddsReset && !csN) csInReset++;
    if (ioUpdate) begin
      updCount++;
      updCyc = cyc;
      if (!csN) csInUpd++;
    end
    if (csN && sclk) idleBad++;
    if (!csN && sclk && prevSclk && sdio != prevSdio) dataBad++;
    if (prevCs && !csN) begin
      bits = 0;
      if (nFrames < 8) csFall[nFrames] = cyc;
    end
    if (!csN && sclk && !prevSclk) begin
      shiftIn = {shiftIn[38:0], sdio};
      bits++;
    end
    if (!prevCs && csN) begin
      if (bits != 40) lenBad++;
      if (nFrames < 8) begin
        frames[nFrames] = shiftIn;
        csRise[nFrames] = cyc;
      end
      nFrames++;
    end
    prevSclk = sclk; prevCs = csN; prevSdio = sdio;
  end

  task automatic printSummary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(posedge clk) begin
    if (cyc > 150000) begin
      chk(1'b0, "watchdog", 64'(cyc), 64'd150000);
      printSummary();
      $finish;
    end
  end

  task automatic waitDone();
    for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
  endtask

  task automatic checkRun(input logic [31:0] ftw, input logic [11:0] amp, input bit exactReset);
    chk(done === 1'b1, "R10 done", 64'(done), 64'd1);
    chk(nFrames == 5, "R11 frame count", 64'(nFrames), 64'd5);
    chk(lenBad == 0 && idleBad == 0 && dataBad == 0, "R2 framing", 64'(lenBad + idleBad + dataBad), 64'd0);
    chk(csInReset == 0, "R1 cs during reset", 64'(csInReset), 64'd0);
    if (exactReset) chk(resetHigh == RST_N, "R1 reset length", 64'(resetHigh), 64'(RST_N));
    else chk(resetHigh >= RST_N - 2 && resetHigh <= RST_N, "R1 reset length after rstN", 64'(resetHigh), 64'(RST_N));
    if (nFrames >= 5) begin
      chk(frames[0] == {8'h03, 32'h0100_0000}, "R3 cal set", frames[0], {8'h03, 32'h0100_0000});
      chk(frames[1] == {8'h03, 32'h0}, "R4 cal clear", frames[1], {8'h03, 32'h0});
      chk(csFall[1] - csRise[0] >= CAL_N, "R4 cal wait", 64'(csFall[1] - csRise[0]), 64'(CAL_N));
      chk(frames[2] == {8'h01, 32'h0080_0000}, "R5 profile mode", frames[2], {8'h01, 32'h0080_0000});
      chk(frames[3] == {8'h0B, ftw}, "R6 tuning word", frames[3], {8'h0B, ftw});
      chk(frames[4] == {8'h0C, 20'h0, amp}, "R7 amplitude", frames[4], {8'h0C, 20'h0, amp});
      chk(updCyc > csRise[4], "R8 update after last frame", 64'(updCyc), 64'(csRise[4]));
    end
    chk(updCount == 1 && csInUpd == 0, "R8 single update", 64'(updCount), 64'd1);
    chk(pinBad == 0, "R9 side-band pins", 64'(pinBad), 64'd0);
  endtask

  task automatic runStart(input logic [31:0] ftw, input logic [11:0] amp);
    @(negedge clk); #1;
    ftwIn = ftw; ampIn = amp;
    clearMon();
    start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    waitDone();
    @(negedge clk);
    checkRun(ftw, amp, 1'b1);
  endtask

  task automatic doReset();
    @(negedge clk); #1;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(ddsReset === 1'b1 && csN === 1'b1 && sclk === 1'b0 && done === 1'b0 && ioUpdate === 1'b0,
        "R1 reset state", {59'd0, ddsReset, csN, sclk, done, ioUpdate}, 64'b11000);
    rstN = 1'b1;
    clearMon();
  endtask

  initial begin
    clearMon();
    // power-up run
    ftwIn = 32'h1234_5678; ampIn = 12'hABC;
    doReset();
    waitDone();
    @(negedge clk);
    checkRun(32'h1234_5678, 12'hABC, 1'b0);

    // R10: done holds with no start
    repeat (50) @(negedge clk);
    chk(done === 1'b1 && updCount == 1, "R10 done holds", 64'(done), 64'd1);

    // sweep of tuning words and amplitudes
    runStart(32'h0000_0000, 12'h000);
    runStart(32'hFFFF_FFFF, 12'hFFF);
    runStart(32'hA5A5_5A5A, 12'h5A5);
    for (int i = 0; i < 32; i++) runStart(32'h1 << i, 12'((i * 131 + 7) & 12'hFFF));

    // R10: start while busy has no effect
    @(negedge clk); #1;
    ftwIn = 32'hCAFE_0001; ampIn = 12'h321;
    clearMon();
    start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    for (int i = 0; i < 20000 && nFrames < 2; i++) @(negedge clk);
    #1 start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    waitDone();
    @(negedge clk);
    checkRun(32'hCAFE_0001, 12'h321, 1'b1);

    // R11: reset mid-sequence restarts from the top
    @(negedge clk); #1;
    ftwIn = 32'h0BAD_F00D; ampIn = 12'h0F0;
    start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    for (int i = 0; i < 20000 && nFrames < 2; i++) @(negedge clk);
    doReset();
    waitDone();
    @(negedge clk);
    checkRun(32'h0BAD_F00D, 12'h0F0, 1'b0);

    printSummary();
    $finish;
  end
endmodule